// File: doc/BRIEF.md
# Write-Busy Status Read Path

This block forms the byte returned to a host read of a byte-wide nonvolatile memory while the memory runs its internal program cycle. During that cycle the host cannot see stored data; every read becomes a status poll. The returned byte gives two independent ways to detect the end of the cycle. The top data bit carries the inverse of the top bit of the last byte loaded. The next bit down flips on every poll. When programming has finished, reads return array data unchanged.

A small state machine follows the write flow. In `ST_IDLE` nothing is pending. An accepted byte load moves it to `ST_LOAD` (transition *load*). A high `busy` flag, seen in either of those states, moves it to `ST_PROG` (transition *begin*). This transition also clears the poll toggle. When `busy` drops, `ST_PROG` returns to `ST_IDLE` (transition *finish*). Byte loads repeat in `ST_LOAD` and keep it there (transition *reload*). Read data is registered and appears one clock after the read strobe.

Top module: `wr_status_read`

## Requirements
- R1: While reset is asserted and after it, with no read yet done, `rd_data` is all zeros and the state machine is in `ST_IDLE`.
- R2: Each `wr_en` accepted outside `ST_PROG` replaces the captured byte. The last byte loaded before programming begins is the one reported by polls.
- R3: A read (`rd_en`) in `ST_PROG` returns, on bit DATA_W-1 (bit 7 at the default width), the complement of the captured byte's bit DATA_W-1.
- R4: Bit DATA_W-2 (bit 6 at the default width) of a poll is 0 on the first poll after programming begins, and it inverts on each further poll in that cycle.
- R5: During polls, bits DATA_W-3 down to 0 equal the same bits of the captured byte.
- R6: `ST_PROG` is entered on the clock edge at which `busy` is first high and is left on the edge at which `busy` is low. A read on the edge where `busy` is first seen high still returns array data.
- R7: Outside `ST_PROG`, a read returns `arr_rdata` as sampled at the read edge, one cycle later on `rd_data`.
- R8: With `rd_en` low, `rd_data` holds its value and the toggle bit does not advance.
- R9: `wr_en` during `ST_PROG` has no effect on the captured byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte load strobe from the host write path |
| wr_data | input | DATA_W | Byte being loaded |
| busy | input | 1 | Internal program cycle in progress |
| rd_en | input | 1 | Host read strobe |
| arr_rdata | input | DATA_W | Data read from the storage array |
| rd_data | output | DATA_W | Registered read value returned to the host |

## Verification
The bench builds the block at the default width of 8 bits. At that width the complemented bit and the toggling bit sit at bit 7 and bit 6, which are the positions a host driver polls. The captured bytes are chosen so that the top bit is both set and clear across the program cycles. This exercises the complement in both directions. The bench also covers reads on the exact edge where `busy` rises, idle cycles placed between polls, and byte loads issued mid-cycle.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } wsr_state_t;
endpackage

// File: rtl/wsr_fsm.sv
module wsr_fsm
    import wsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       busy,
    output wsr_state_t state_q,
    output logic       enter_prog
);
    wsr_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (busy)       state_d = ST_PROG;
                else if (wr_en) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (busy)       state_d = ST_PROG;
            end
            ST_PROG: begin
                if (!busy)      state_d = ST_IDLE;
            end
            default:            state_d = ST_IDLE;
        endcase
    end

    always_comb enter_prog = (state_q != ST_PROG) && busy;

    assert_begin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_PROG && busy) |=> (state_q == ST_PROG));
    assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && !busy) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/wsr_capture.sv
module wsr_capture
    import wsr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  wsr_state_t        state_q,
    output logic [DATA_W-1:0] last_q
);
    logic take;

    always_comb take = wr_en && (state_q != ST_PROG);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    last_q <= '0;
        else if (take) last_q <= wr_data;
    end

    assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG) |=> $stable(last_q));
endmodule

// File: rtl/wsr_toggle.sv
module wsr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic enter_prog,
    input  logic poll,
    output logic tog_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          tog_q <= 1'b0;
        else if (enter_prog) tog_q <= 1'b0;
        else if (poll)       tog_q <= ~tog_q;
    end

    assert_tog_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!poll && !enter_prog) |=> $stable(tog_q));
endmodule

// File: rtl/wr_status_read.sv
module wr_status_read
    import wsr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rd_data
);
    localparam int INV_BIT = DATA_W - 1;
    localparam int TOG_BIT = DATA_W - 2;
    localparam int LOW_W   = DATA_W - 2;

    wsr_state_t        state_q;
    logic              enter_prog;
    logic [DATA_W-1:0] last_q;
    logic              tog_q;
    logic              poll;
    logic [DATA_W-1:0] status_word;

    wsr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy),
        .state_q(state_q), .enter_prog(enter_prog)
    );

    wsr_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .state_q(state_q), .last_q(last_q)
    );

    wsr_toggle u_tog (
        .clk(clk), .rst_n(rst_n), .enter_prog(enter_prog),
        .poll(poll), .tog_q(tog_q)
    );

    always_comb begin
        poll        = rd_en && (state_q == ST_PROG);
        status_word = {~last_q[INV_BIT], tog_q, last_q[LOW_W-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (poll)  rd_data <= status_word;
        else if (rd_en) rd_data <= arr_rdata;
    end

    assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && state_q != ST_PROG) |=> (rd_data == $past(arr_rdata)));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
    assert_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (poll && $past(poll) && $past(state_q) == ST_PROG)
            |=> (rd_data[TOG_BIT] != $past(rd_data[TOG_BIT])));
    assert_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        poll |=> (rd_data[LOW_W-1:0] == $past(last_q[LOW_W-1:0])));
endmodule

// File: tb/wr_status_read_bench.sv
`timescale 1ns/1ps
module wr_status_read_bench;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          busy = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] arr_rdata = '0;
    logic [DW-1:0] rd_data;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wr_status_read #(.DATA_W(DW)) u_wr_status_read (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .busy(busy), .rd_en(rd_en), .arr_rdata(arr_rdata), .rd_data(rd_data)
    );

    // Behavioural reference: 0 idle, 1 loading, 2 programming
    int            m_mode = 0;
    logic [DW-1:0] m_last = '0;
    bit            m_tog = 1'b0;
    logic [DW-1:0] m_rd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_last = '0; m_tog = 1'b0; m_rd = '0;
        end else begin
            if (rd_en) begin
                if (m_mode == 2) begin
                    m_rd = {~m_last[DW-1], m_tog, m_last[DW-3:0]};
                    m_tog = ~m_tog;
                end else begin
                    m_rd = arr_rdata;
                end
            end
            if (m_mode != 2 && wr_en) m_last = wr_data;
            if (m_mode == 2) begin
                if (!busy) m_mode = 0;
            end else if (busy) begin
                m_mode = 2; m_tog = 1'b0;
            end else if (wr_en) begin
                m_mode = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_run++;
            if (rd_data !== m_rd) begin
                n_fail++;
                $display("FAIL R3 model compare: actual %h expected %h", rd_data, m_rd);
            end
        end
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // call at a negedge; applies inputs for one cycle and returns at next negedge
    task automatic cyc(input bit w, input logic [DW-1:0] wd, input bit r, input logic [DW-1:0] ar);
        wr_en = w; wr_data = wd; rd_en = r; arr_rdata = ar;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #20000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset value", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", rd_data, 8'h00);

        cyc(0, 0, 1, 8'h5A);
        chk("R7 idle read", rd_data, 8'h5A);

        cyc(1, 8'h11, 0, 0);
        cyc(1, 8'h22, 0, 0);
        cyc(1, 8'hC3, 1, 8'h3C);
        chk("R7 read while loading", rd_data, 8'h3C);
        busy = 1'b1;
        cyc(0, 0, 0, 0);
        cyc(0, 0, 1, 8'hFF);
        chk("R3 first poll", rd_data, 8'h03);
        chk("R2 last byte wins low bits", {2'b00, rd_data[5:0]}, 8'h03);
        cyc(0, 0, 1, 8'hFF);
        chk("R4 second poll toggles", rd_data, 8'h43);
        cyc(1, 8'h00, 0, 0);
        chk("R8 hold without read", rd_data, 8'h43);
        cyc(0, 0, 1, 8'hFF);
        chk("R9 write ignored in programming", rd_data, 8'h03);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 1, 8'hFF);
        chk("R8 toggle did not advance", rd_data, 8'h43);
        cyc(0, 0, 1, 8'hFF);
        chk("R5 low bits", rd_data, 8'h03);

        busy = 1'b0;
        cyc(0, 0, 1, 8'hEE);
        chk("R6 read on finish edge still polls", rd_data, 8'h43);
        cyc(0, 0, 1, 8'h99);
        chk("R7 true data after finish", rd_data, 8'h99);

        busy = 1'b1;
        cyc(0, 0, 1, 8'h77);
        chk("R6 read on begin edge returns array", rd_data, 8'h77);
        cyc(0, 0, 1, 8'hFF);
        chk("R4 toggle cleared at begin", rd_data, 8'h03);
        busy = 1'b0;
        cyc(0, 0, 0, 0);

        cyc(1, 8'h2A, 0, 0);
        busy = 1'b1;
        cyc(0, 0, 0, 0);
        cyc(0, 0, 1, 8'h00);
        chk("R3 complement of clear top bit", rd_data, 8'hAA);
        cyc(0, 0, 1, 8'h00);
        chk("R4 second poll sets bit 6", rd_data, 8'hEA);
        busy = 1'b0;
        cyc(0, 0, 0, 0);
        cyc(0, 0, 1, 8'h2A);
        chk("R7 stored data after cycle", rd_data, 8'h2A);

        @(negedge clk);
        finish_run();
    end
endmodule